// File: doc/BRIEF.md
# Pin Controller with Per-Pin Interrupt Detection

This block gives a processor control over a small group of general-purpose pins through a 32-bit word-addressed register port. Each pin can drive a level or be read back. Each pin can also raise an interrupt under a trigger condition chosen per pin. Triggered events are latched into a status word. Software clears that word by writing ones. A mask word, reached through separate write-one-to-set and write-one-to-clear addresses, gates which latched events reach the single combined interrupt line.

The pin count is a parameter, either 12 or 8. Register reads are combinational from the word index. A write takes effect at the clock edge on which it is presented. A soft-reset word holds every other register at its reset value for as long as its bit 0 is one.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word indices are 0 enable, 1 status, 2 masked status, 3 status clear, 4 mask set, 5 mask clear, 6 output value, 7 input value, 8 direction, 9 trigger modes of pins 0-7, 10 trigger modes of pins 8-11, 14 use-select and 15 soft reset. After reset every register reads zero except the mask, which reads all ones at indices 4 and 5.
- R2: `pin_out` follows the output-value register. `pin_oe` bit i is 1 exactly when direction bit i is 1.
- R3: Index 7 returns the pin levels after a two-flop synchroniser. A level applied before clock edge k reads back after edge k+1.
- R4: The trigger mode of pin i is held in bits 4*(i%8)+2 to 4*(i%8) of index 9 (pins 0-7) or index 10 (pins 8-11), and bit 3 of each nibble reads zero. The codes are 0 falling, 1 rising, 2 level low, 3 level high and 4 both edges. Codes 5 to 7 never trigger. An edge applied to a pin before clock edge k shows in status after edge k+2 and not before.
- R5: A status bit sets only when the enable bit of that pin is one.
- R6: A one written at index 3 clears that status bit, and a zero bit has no effect. In a level mode the bit sets again on every cycle while the level persists, even on the cycle of a clear.
- R7: A one written at index 4 masks that pin, and a one written at index 5 unmasks it. Zero bits leave the mask unchanged.
- R8: `irq` is one exactly when some status bit is set and unmasked. Index 2 reads status AND NOT mask.
- R9: Bits at or above the pin count are ignored on writes and read as zero in the enable, status, direction, output and mask words.
- R10: While soft-reset bit 0 is one, every other register holds its reset value and ignores writes. Writing zero releases them. Index 15 reads the bit back.
- R11: Use-select is a plain read/write word with no other effect. Indices 11 to 13 and index 3 read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Word index of the register accessed |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| pin_in | input | NPIN | Raw pin levels |
| pin_out | output | NPIN | Driven pin levels |
| pin_oe | output | NPIN | Per-pin output enable |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The bench samples status one cycle before and on the cycle an edge should land. A design with one synchroniser stage too few or too many is therefore caught. It clears a level-high status while the level persists, and a design that lets the clear win would show zero. The unused mode code 5, a disabled pin and a mode in the wrong edge direction must all leave status empty, which catches decoders that fall through to an edge mode. Soft reset is probed with writes issued while it is held. Mode fields are written all ones to catch a nibble placed at the wrong bit offset or a bit 3 that is stored.

// File: rtl/gpio_irq_pkg.sv
// Shared word indices and trigger-mode codes for the pin controller.
package gpio_irq_pkg;
    localparam int REG_AW = 4;

    // Word indices; software decodes these positions.
    localparam logic [REG_AW-1:0] A_EN    = 4'd0;
    localparam logic [REG_AW-1:0] A_STAT  = 4'd1;
    localparam logic [REG_AW-1:0] A_DISP  = 4'd2;
    localparam logic [REG_AW-1:0] A_CLR   = 4'd3;
    localparam logic [REG_AW-1:0] A_MSET  = 4'd4;
    localparam logic [REG_AW-1:0] A_MCLR  = 4'd5;
    localparam logic [REG_AW-1:0] A_OUT   = 4'd6;
    localparam logic [REG_AW-1:0] A_IN    = 4'd7;
    localparam logic [REG_AW-1:0] A_DIR   = 4'd8;
    localparam logic [REG_AW-1:0] A_MODE0 = 4'd9;
    localparam logic [REG_AW-1:0] A_MODE1 = 4'd10;
    localparam logic [REG_AW-1:0] A_USE   = 4'd14;
    localparam logic [REG_AW-1:0] A_SRST  = 4'd15;

    // Trigger encodings, three bits per pin.
    localparam logic [2:0] TRIG_FALL = 3'd0;
    localparam logic [2:0] TRIG_RISE = 3'd1;
    localparam logic [2:0] TRIG_LOW  = 3'd2;
    localparam logic [2:0] TRIG_HIGH = 3'd3;
    localparam logic [2:0] TRIG_BOTH = 3'd4;

    localparam int MODE_W     = 3;
    localparam int NIBBLE_W   = 4;
    localparam int PINS_PER_W = 8;
endpackage

// File: rtl/gpio_irq_sync.sv
// Two-flop synchroniser with one extra history stage.
// Assumes pin_in is asynchronous to clk; cur is the settled sample and
// prev is the sample from the cycle before, for edge comparison.
module gpio_irq_sync #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta;

    // Shift raw levels through the two sync stages and the history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= pin_in;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger decoder. Compares the current and previous synchronised
// samples under each pin's 3-bit mode. Assumes codes 5..7 never trigger.
module gpio_irq_detect
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 12
) (
    input  logic [NPIN-1:0]             cur,
    input  logic [NPIN-1:0]             prev,
    input  logic [NPIN-1:0][MODE_W-1:0] mode,
    output logic [NPIN-1:0]             hit
);
    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        logic rise_g, fall_g;
        assign rise_g = cur[g] & ~prev[g];
        assign fall_g = ~cur[g] & prev[g];

        // Select the trigger condition for this pin from its mode code.
        always_comb begin
            case (mode[g])
                TRIG_FALL: hit[g] = fall_g;
                TRIG_RISE: hit[g] = rise_g;
                TRIG_LOW:  hit[g] = ~cur[g];
                TRIG_HIGH: hit[g] = cur[g];
                TRIG_BOTH: hit[g] = rise_g | fall_g;
                default:   hit[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_regfile.sv
// Register state of the pin controller: enable, status, mask, output,
// direction, modes, use-select and the soft-reset bit. Assumes a single
// write per cycle. The soft-reset bit forces all other state to reset values.
module gpio_irq_regfile
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 12
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr,
    input  logic [REG_AW-1:0]           addr,
    input  logic [31:0]                 wdata,
    input  logic [NPIN-1:0]             hit,
    output logic [NPIN-1:0]             en,
    output logic [NPIN-1:0]             status,
    output logic [NPIN-1:0]             mask,
    output logic [NPIN-1:0]             outv,
    output logic [NPIN-1:0]             dir,
    output logic [NPIN-1:0]             usesel,
    output logic [NPIN-1:0][MODE_W-1:0] mode,
    output logic                        srst
);
    localparam logic [NPIN-1:0] ALL_ONES = '1;

    logic            soft_clr;
    logic [NPIN-1:0] wbits, clr_bits, set_msk, clr_msk;

    assign wbits    = wdata[NPIN-1:0];
    assign soft_clr = srst | (wr && addr == A_SRST && wdata[0]);
    assign clr_bits = (wr && addr == A_CLR)  ? wbits : '0;
    assign set_msk  = (wr && addr == A_MSET) ? wbits : '0;
    assign clr_msk  = (wr && addr == A_MCLR) ? wbits : '0;

    // Soft-reset bit follows bit 0 of writes to its word.
    always_ff @(posedge clk) begin
        if (!rst_n)                   srst <= 1'b0;
        else if (wr && addr == A_SRST) srst <= wdata[0];
    end

    // Plain configuration words, held at reset while soft reset is active.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            en     <= '0;
            outv   <= '0;
            dir    <= '0;
            usesel <= '0;
        end else if (wr) begin
            if (addr == A_EN)  en     <= wbits;
            if (addr == A_OUT) outv   <= wbits;
            if (addr == A_DIR) dir    <= wbits;
            if (addr == A_USE) usesel <= wbits;
        end
    end

    // Trigger modes, pins 0-7 from word 9 and pins 8 up from word 10.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) begin
            mode <= '0;
        end else if (wr) begin
            for (int i = 0; i < NPIN; i++) begin
                if ((i < PINS_PER_W && addr == A_MODE0) ||
                    (i >= PINS_PER_W && addr == A_MODE1))
                    mode[i] <= wdata[NIBBLE_W*(i%PINS_PER_W) +: MODE_W];
            end
        end
    end

    // Mask: write-one set and write-one clear, all masked at reset.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) mask <= ALL_ONES;
        else                    mask <= (mask | set_msk) & ~clr_msk;
    end

    // Status: enabled hits set, write-one clears; a hit wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_clr) status <= '0;
        else                    status <= (status & ~clr_bits) | (hit & en);
    end

    AST_SRST_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        srst |-> (mask == ALL_ONES && en == '0 && status == '0)); // R10

    for (genvar g = 0; g < NPIN; g++) begin : g_ast
        AST_SET_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(status[g]) |-> $past(en[g])); // R5
        AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == A_CLR && wdata[g] && !hit[g]) |=> !status[g]); // R6
        AST_MASK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == A_MSET && wdata[g]) |=> mask[g]); // R7
        AST_MASK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && addr == A_MCLR && wdata[g] && !srst) |=> !mask[g]); // R7
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// Top of the pin controller: synchroniser, trigger decoder, register state
// and the combinational read mux. Assumes NPIN is 8 or 12 and that the bus
// side presents one access per cycle with reads sampled combinationally.
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPIN = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic [NPIN-1:0]   pin_in,
    output logic [NPIN-1:0]   pin_out,
    output logic [NPIN-1:0]   pin_oe,
    output logic              irq
);
    logic [NPIN-1:0]             cur, prev, hit;
    logic [NPIN-1:0]             en, status, mask, outv, dir, usesel;
    logic [NPIN-1:0][MODE_W-1:0] mode;
    logic                        srst;
    logic [NPIN-1:0]             shown;

    gpio_irq_sync #(.W(NPIN)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cur(cur), .prev(prev)
    );

    gpio_irq_detect #(.NPIN(NPIN)) u_det (
        .cur(cur), .prev(prev), .mode(mode), .hit(hit)
    );

    gpio_irq_regfile #(.NPIN(NPIN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .hit(hit), .en(en), .status(status),
        .mask(mask), .outv(outv), .dir(dir), .usesel(usesel),
        .mode(mode), .srst(srst)
    );

    assign shown   = status & ~mask;
    assign irq     = |shown;
    assign pin_out = outv;
    assign pin_oe  = dir;

    // Read mux: zero-extend pin words, pack mode nibbles, zero elsewhere.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_EN:            reg_rdata[NPIN-1:0] = en;
            A_STAT:          reg_rdata[NPIN-1:0] = status;
            A_DISP:          reg_rdata[NPIN-1:0] = shown;
            A_MSET, A_MCLR:  reg_rdata[NPIN-1:0] = mask;
            A_OUT:           reg_rdata[NPIN-1:0] = outv;
            A_IN:            reg_rdata[NPIN-1:0] = cur;
            A_DIR:           reg_rdata[NPIN-1:0] = dir;
            A_USE:           reg_rdata[NPIN-1:0] = usesel;
            A_SRST:          reg_rdata[0]        = srst;
            A_MODE0, A_MODE1: begin
                for (int i = 0; i < NPIN; i++) begin
                    if ((i < PINS_PER_W) == (reg_addr == A_MODE0))
                        reg_rdata[NIBBLE_W*(i%PINS_PER_W) +: MODE_W] = mode[i];
                end
            end
            default:         reg_rdata = '0;
        endcase
    end

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_DIR || reg_addr == A_STAT) |-> reg_rdata[31:NPIN] == '0); // R9
    AST_IRQ_MATCHES_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_DISP) |-> (irq == (reg_rdata != 32'd0))); // R8
endmodule

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;
    localparam int CLK_P = 10;
    localparam int NPIN  = 12;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [3:0]  reg_addr = 0;
    logic        reg_wr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic [NPIN-1:0] pin_in = 0;
    logic [NPIN-1:0] pin_out, pin_oe;
    logic        irq;
    int n_run = 0, n_fail = 0;
    bit done = 0;

    gpio_irq_ctrl #(.NPIN(NPIN)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(0, v);  check("R1 enable reset", v, 0);
        rd(4, v);  check("R1 mask reset idx4", v, 32'hFFF);
        rd(5, v);  check("R1 mask reset idx5", v, 32'hFFF);
        rd(8, v);  check("R1 dir reset", v, 0);
        check("R8 irq at reset", {31'd0, irq}, 0);
    endtask

    task automatic t_out_dir();
        logic [31:0] v;
        wr(8, 32'hFFFF_FFFF);
        rd(8, v); check("R9 dir upper bits", v, 32'hFFF);
        check("R2 pin_oe", {20'd0, pin_oe}, 32'hFFF);
        wr(6, 32'h0000_FA5A);
        rd(6, v); check("R9 out upper bits", v, 32'hA5A);
        check("R2 pin_out", {20'd0, pin_out}, 32'hA5A);
        wr(8, 32'h0000_0003);
        check("R2 pin_oe partial", {20'd0, pin_oe}, 32'h3);
        wr(0, 32'hFFFF_FFFF);
        rd(0, v); check("R9 enable upper bits", v, 32'hFFF);
        wr(0, 0);
    endtask

    task automatic t_input();
        logic [31:0] v;
        pin_in = 12'h005;
        tick(1); rd(7, v); check("R3 input not yet", v, 0);
        tick(1); rd(7, v); check("R3 input synced", v, 32'h5);
    endtask

    task automatic t_mode_fields();
        logic [31:0] v;
        wr(9, 32'hFFFF_FFFF);  rd(9, v);  check("R4 mode0 field layout", v, 32'h7777_7777);
        wr(10, 32'hFFFF_FFFF); rd(10, v); check("R4 mode1 field layout", v, 32'h0000_7777);
        wr(9, 0); wr(10, 0);
    endtask

    task automatic t_rise();
        logic [31:0] v;
        wr(9, 32'h0000_0010);  // pin1 rising
        wr(0, 32'h002);
        wr(3, 32'hFFF);
        pin_in[1] = 1;
        tick(2); rd(1, v); check("R4 rise not before k+2", v, 0);
        tick(1); rd(1, v); check("R4 rise latched", v, 32'h2);
        wr(3, 32'h001);
        rd(1, v); check("R6 clear zero bit no effect", v, 32'h2);
    endtask

    task automatic t_fall();
        logic [31:0] v;
        wr(0, 32'h200);        // pin9, mode1 nibble1 = 0 falling
        pin_in[9] = 1;
        tick(3); rd(1, v); check("R4 falling ignores rise", v, 32'h2);
        wr(3, 32'hFFF);
        rd(1, v); check("R6 clear all", v, 0);
        pin_in[9] = 0;
        tick(3); rd(1, v); check("R4 falling on pin9", v, 32'h200);
    endtask

    task automatic t_both();
        logic [31:0] v;
        wr(9, 32'h0000_0410);  // pin2 both edges
        wr(0, 32'h004);
        wr(3, 32'hFFF);
        pin_in[2] = 0;
        tick(3); rd(1, v); check("R4 both-edge fall", v, 32'h4);
        wr(3, 32'h004);
        rd(1, v); check("R6 edge status cleared", v, 0);
        pin_in[2] = 1;
        tick(3); rd(1, v); check("R4 both-edge rise", v, 32'h4);
    endtask

    task automatic t_enable();
        logic [31:0] v;
        wr(0, 0);
        wr(9, 32'h0000_1000);  // pin3 rising
        wr(3, 32'hFFF);
        pin_in[3] = 1;
        tick(3); rd(1, v); check("R5 disabled pin stays clear", v, 0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        wr(9, 32'h0023_0000);  // pin4 level high, pin5 level low
        wr(0, 32'h010);
        pin_in[4] = 1;
        tick(3); rd(1, v); check("R4 level high", v, 32'h10);
        wr(3, 32'h010);
        rd(1, v); check("R6 level re-sets after clear", v, 32'h10);
        pin_in[4] = 0;
        tick(3);
        wr(3, 32'h010);
        rd(1, v); check("R6 level gone, clear holds", v, 0);
        wr(0, 32'h020);
        tick(2); rd(1, v); check("R4 level low", v, 32'h20);
        wr(0, 0); wr(3, 32'hFFF);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(9, 32'h0003_0000);
        wr(0, 32'h010);
        pin_in[4] = 1;
        tick(3);
        check("R8 masked, irq low", {31'd0, irq}, 0);
        rd(2, v); check("R8 display masked", v, 0);
        wr(5, 32'h010);
        rd(4, v); check("R7 mask clear bit4", v, 32'hFEF);
        check("R8 irq when unmasked", {31'd0, irq}, 1);
        rd(2, v); check("R8 display unmasked", v, 32'h10);
        wr(5, 0);
        rd(5, v); check("R7 zero write no effect", v, 32'hFEF);
        wr(4, 32'h010);
        rd(4, v); check("R7 mask set bit4", v, 32'hFFF);
        check("R8 irq after remask", {31'd0, irq}, 0);
    endtask

    task automatic t_unused_code();
        logic [31:0] v;
        wr(9, 32'h0500_0000);  // pin6 code 5
        wr(0, 32'h040);
        wr(3, 32'hFFF);
        pin_in[6] = 1; tick(3);
        pin_in[6] = 0; tick(3);
        rd(1, v); check("R4 code 5 never triggers", v, 0);
    endtask

    task automatic t_misc();
        logic [31:0] v;
        wr(14, 32'h0000_0ABC); rd(14, v); check("R11 use-select readback", v, 32'hABC);
        rd(11, v); check("R11 reserved 11", v, 0);
        rd(12, v); check("R11 reserved 12", v, 0);
        rd(13, v); check("R11 reserved 13", v, 0);
        rd(3, v);  check("R11 clear word reads zero", v, 0);
    endtask

    task automatic t_softreset();
        logic [31:0] v;
        wr(9, 32'h0003_0000);
        wr(0, 32'hFFF);
        wr(8, 32'h00F);
        wr(5, 32'hFFF);
        tick(1);
        rd(1, v); check("R10 status set before reset", v[4], 1);
        wr(15, 1);
        rd(15, v); check("R10 reset bit reads back", v, 1);
        rd(8, v);  check("R10 dir cleared", v, 0);
        rd(0, v);  check("R10 enable cleared", v, 0);
        rd(4, v);  check("R10 mask all ones", v, 32'hFFF);
        rd(1, v);  check("R10 status cleared", v, 0);
        rd(14, v); check("R10 use-select cleared", v, 0);
        rd(9, v);  check("R10 modes cleared", v, 0);
        wr(8, 32'h00F);
        rd(8, v);  check("R10 write ignored while held", v, 0);
        wr(15, 0);
        rd(8, v);  check("R10 stays reset after release", v, 0);
        wr(8, 32'h001);
        rd(8, v);  check("R10 writes resume", v, 1);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        tick(4);
        rst_n = 1;
        tick(1);
        t_reset();
        t_out_dir();
        t_input();
        t_mode_fields();
        t_rise();
        t_fall();
        t_both();
        t_enable();
        t_level();
        t_mask();
        t_unused_code();
        t_misc();
        t_softreset();
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule